// File: doc/BRIEF.md
# Window Range Detector for DAC Codes

This block watches a stream of 12-bit DAC output codes and decides, one sample at a time, whether each code meets a programmed range condition. Three shared limit slots each hold a 2-bit condition code and a pair of 12-bit thresholds. A status selector arrives with every sample. It names the slot to apply, or it turns checking off for that sample.

The block registers the verdict and presents it one clock after the sample strobe, along with a result-valid flag. Each slot also has a sticky flag. The flag records that its condition was met at least once, and it stays set until a clear pulse removes it. A sign input chooses how codes and thresholds are compared: as two's-complement values or as plain unsigned values.

Top module: `range_window_det`

## Requirements
- R1: Condition code 0 ("under") is met when the code is strictly less than the slot's low threshold.
- R2: Condition code 1 ("window") is met when low <= code and code < high.
- R3: Condition code 2 ("over") is met when the code is strictly greater than the slot's high threshold.
- R4: Condition code 3 ("escape") is met when code < low or code >= high.
- R5: Selector value 0 turns checking off. Values 1, 2 and 3 apply slots 0, 1 and 2. Slot k takes its condition from `lim_cond[2k+1:2k]`, its low threshold from `lim_lo[12k+11:12k]` and its high threshold from `lim_hi[12k+11:12k]`.
- R6: When `sign_en` is 1, the code and both thresholds are compared as 12-bit two's-complement values. When it is 0, they are compared as unsigned values.
- R7: `res_vld` is high exactly in the cycle after a cycle with `smp_vld` high. `hit` reflects that sample's verdict and is low whenever `res_vld` is low.
- R8: A sample taken with the selector at 0 gives `hit` low and sets no sticky flag.
- R9: A checked sample whose condition is met sets the sticky flag of the selected slot only, visible in the next cycle.
- R10: A sticky flag stays set until its `sticky_clr` bit is pulsed. When a set and a clear reach the same slot in the same cycle, the set wins.
- R11: While `rst_n` is low, `hit`, `res_vld` and all sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sign_en | input | 1 | 1: compare as two's complement; 0: compare as unsigned |
| smp_vld | input | 1 | Sample strobe |
| smp_code | input | 12 | DAC code under test |
| smp_sel | input | 2 | Status selector: 0 turns checking off, 1..3 apply slots 0..2 |
| lim_cond | input | 6 | Condition code of each slot, 2 bits per slot |
| lim_lo | input | 36 | Low threshold of each slot, 12 bits per slot |
| lim_hi | input | 36 | High threshold of each slot, 12 bits per slot |
| sticky_clr | input | 3 | Write-one-to-clear pulse, one bit per slot |
| hit | output | 1 | Registered verdict for the last strobed sample |
| res_vld | output | 1 | Verdict valid, one cycle after the strobe |
| sticky | output | 3 | Sticky condition-met flag, one bit per slot |

## Verification
Some behaviours are checked by assertions on every cycle:
- the result-valid flag follows the strobe by exactly one cycle;
- `hit` is never high without `res_vld`;
- a sample with checking turned off never produces a hit;
- a sticky flag only rises after a sample that selected its slot;
- a sticky flag holds until a clear arrives, and drops after a clear that no sample opposes.

Other behaviours can only be shown by the bench's scenarios:
- the arithmetic of the four condition codes at their boundary values, where inclusive and exclusive bounds differ by a single code;
- the change in verdict between signed and unsigned comparison for the same bit pattern;
- the set-wins-over-clear priority.

// File: rtl/rdet_pkg.sv
package rdet_pkg;

    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        COND_UNDER  = 2'd0,
        COND_WINDOW = 2'd1,
        COND_OVER   = 2'd2,
        COND_ESCAPE = 2'd3
    } cond_e;

endpackage

// File: rtl/rdet_eval.sv
module rdet_eval
    import rdet_pkg::*;
#(
    parameter int DW = CODE_W
) (
    input  logic          sign_en,
    input  cond_e         cond,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] code,
    output logic          met
);

    logic below_lo;
    logic below_hi;
    logic above_hi;

    always_comb begin
        if (sign_en) begin
            below_lo = $signed(code) < $signed(lo);
            below_hi = $signed(code) < $signed(hi);
            above_hi = $signed(code) > $signed(hi);
        end else begin
            below_lo = code < lo;
            below_hi = code < hi;
            above_hi = code > hi;
        end

        unique case (cond)
            COND_UNDER:  met = below_lo;
            COND_WINDOW: met = !below_lo && below_hi;
            COND_OVER:   met = above_hi;
            COND_ESCAPE: met = below_lo || !below_hi;
            default:     met = 1'b0;
        endcase
    end

endmodule

// File: rtl/rdet_pick.sv
module rdet_pick #(
    parameter int NSLOT = 3,
    parameter int SW    = $clog2(NSLOT + 1)
) (
    input  logic [SW-1:0]    sel,
    input  logic [NSLOT-1:0] met_all,
    output logic [NSLOT-1:0] pick_oh,
    output logic             met_sel
);

    for (genvar k = 0; k < NSLOT; k++) begin : g_dec
        assign pick_oh[k] = (sel == SW'(k + 1));
    end

    assign met_sel = |(pick_oh & met_all);

endmodule

// File: rtl/range_window_det.sv
module range_window_det
    import rdet_pkg::*;
#(
    parameter int DW    = CODE_W,
    parameter int NSLOT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sign_en,
    input  logic                smp_vld,
    input  logic [DW-1:0]       smp_code,
    input  logic [1:0]          smp_sel,
    input  logic [2*NSLOT-1:0]  lim_cond,
    input  logic [DW*NSLOT-1:0] lim_lo,
    input  logic [DW*NSLOT-1:0] lim_hi,
    input  logic [NSLOT-1:0]    sticky_clr,
    output logic                hit,
    output logic                res_vld,
    output logic [NSLOT-1:0]    sticky
);

    localparam int SW = 2;

    typedef struct packed {
        logic             hit;
        logic             vld;
        logic [NSLOT-1:0] stk;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [NSLOT-1:0] met_all;
    logic [NSLOT-1:0] pick_oh;
    logic             met_sel;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        rdet_eval #(.DW(DW)) u_eval (
            .sign_en (sign_en),
            .cond    (cond_e'(lim_cond[2*k +: 2])),
            .lo      (lim_lo[DW*k +: DW]),
            .hi      (lim_hi[DW*k +: DW]),
            .code    (smp_code),
            .met     (met_all[k])
        );
    end

    rdet_pick #(.NSLOT(NSLOT), .SW(SW)) u_pick (
        .sel     (smp_sel),
        .met_all (met_all),
        .pick_oh (pick_oh),
        .met_sel (met_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = smp_vld;
        st_d.hit = smp_vld && met_sel;
        st_d.stk = (st_q.stk & ~sticky_clr)
                 | ({NSLOT{smp_vld}} & pick_oh & met_all);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit     = st_q.hit;
    assign res_vld = st_q.vld;
    assign sticky  = st_q.stk;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> res_vld); // R7
    AST_HIT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> res_vld); // R7
    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && smp_sel == 2'd0) |=> !hit); // R8

    for (genvar k = 0; k < NSLOT; k++) begin : g_chk
        AST_STICKY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sticky[k]) |-> $past(smp_vld && smp_sel == SW'(k + 1))); // R9
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky[k] && !sticky_clr[k]) |=> sticky[k]); // R10
        AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_clr[k] && !smp_vld) |=> !sticky[k]); // R10
    end

endmodule

// File: tb/tb_range_window_det.sv
module tb_range_window_det;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sign_en;
    logic        smp_vld;
    logic [11:0] smp_code;
    logic [1:0]  smp_sel;
    logic [5:0]  lim_cond;
    logic [35:0] lim_lo;
    logic [35:0] lim_hi;
    logic [2:0]  sticky_clr;
    logic        hit;
    logic        res_vld;
    logic [2:0]  sticky;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [2:0] exp_stk = '0;

    always #4 clk = ~clk;

    range_window_det dut (
        .clk(clk), .rst_n(rst_n), .sign_en(sign_en), .smp_vld(smp_vld),
        .smp_code(smp_code), .smp_sel(smp_sel), .lim_cond(lim_cond),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .sticky_clr(sticky_clr),
        .hit(hit), .res_vld(res_vld), .sticky(sticky)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int to_int(input logic [11:0] v, input logic s);
        if (s) return int'($signed(v));
        return int'({20'd0, v});
    endfunction

    function automatic logic model(input int slot, input logic [11:0] v);
        int x, l, h;
        x = to_int(v, sign_en);
        l = to_int(lim_lo[12*slot +: 12], sign_en);
        h = to_int(lim_hi[12*slot +: 12], sign_en);
        case (lim_cond[2*slot +: 2])
            2'd0:    return x < l;
            2'd1:    return (x >= l) && (x < h);
            2'd2:    return x > h;
            default: return (x < l) || (x >= h);
        endcase
    endfunction

    task automatic set_slot(input int k, input logic [1:0] c,
                            input logic [11:0] l, input logic [11:0] h);
        lim_cond[2*k +: 2] = c;
        lim_lo[12*k +: 12] = l;
        lim_hi[12*k +: 12] = h;
    endtask

    task automatic apply(input string req, input logic [1:0] sel,
                         input logic [11:0] code, input logic [2:0] clr);
        logic e;
        @(negedge clk);
        smp_vld = 1'b1; smp_sel = sel; smp_code = code; sticky_clr = clr;
        e = (sel != 2'd0) && model(int'(sel) - 1, code);
        exp_stk = exp_stk & ~clr;
        if (e) exp_stk[sel - 1] = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; sticky_clr = '0;
        check({req, " hit"}, int'(hit), int'(e));
        check({req, " res_vld"}, int'(res_vld), 1);
        check({req, " sticky"}, int'(sticky), int'(exp_stk));
    endtask

    task automatic clear(input logic [2:0] clr);
        @(negedge clk);
        sticky_clr = clr;
        exp_stk = exp_stk & ~clr;
        @(negedge clk);
        sticky_clr = '0;
        check("R10 clear", int'(sticky), int'(exp_stk));
        check("R7 idle hit", int'(hit), 0);
        check("R7 idle vld", int'(res_vld), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; sign_en = 1'b0; smp_vld = 1'b0; smp_code = '0;
        smp_sel = '0; sticky_clr = '0; lim_cond = '0; lim_lo = '0; lim_hi = '0;
        repeat (3) @(negedge clk);
        check("R11 hit", int'(hit), 0);
        check("R11 vld", int'(res_vld), 0);
        check("R11 sticky", int'(sticky), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_under;
        set_slot(0, 2'd0, 12'd100, 12'd200);
        apply("R1 99", 2'd1, 12'd99, 3'b000);
        apply("R1 100", 2'd1, 12'd100, 3'b000);
        clear(3'b001);
    endtask

    task automatic t_window;
        set_slot(1, 2'd1, 12'd100, 12'd200);
        apply("R2 99", 2'd2, 12'd99, 3'b000);
        apply("R2 100", 2'd2, 12'd100, 3'b000);
        apply("R2 199", 2'd2, 12'd199, 3'b000);
        apply("R2 200", 2'd2, 12'd200, 3'b000);
        clear(3'b010);
    endtask

    task automatic t_over;
        set_slot(2, 2'd2, 12'd100, 12'd200);
        apply("R3 200", 2'd3, 12'd200, 3'b000);
        apply("R3 201", 2'd3, 12'd201, 3'b000);
        clear(3'b100);
    endtask

    task automatic t_escape;
        set_slot(0, 2'd3, 12'd100, 12'd200);
        apply("R4 99", 2'd1, 12'd99, 3'b000);
        apply("R4 150", 2'd1, 12'd150, 3'b000);
        apply("R4 200", 2'd1, 12'd200, 3'b000);
        clear(3'b001);
    endtask

    task automatic t_signed;
        set_slot(1, 2'd1, 12'hFCE, 12'h032);
        sign_en = 1'b1;
        apply("R6 signed -10", 2'd2, 12'hFF6, 3'b000);
        sign_en = 1'b0;
        apply("R6 unsigned 0xFF6", 2'd2, 12'hFF6, 3'b000);
        clear(3'b010);
    endtask

    task automatic t_off_and_isolation;
        set_slot(0, 2'd3, 12'd0, 12'd0);
        set_slot(1, 2'd3, 12'd0, 12'd0);
        set_slot(2, 2'd3, 12'd0, 12'd0);
        apply("R8 off", 2'd0, 12'd5, 3'b000);
        check("R8 sticky none", int'(sticky), 0);
        apply("R5 R9 slot2 only", 2'd3, 12'd5, 3'b000);
        check("R9 only slot2", int'(sticky), 4);
        apply("R10 set wins", 2'd3, 12'd5, 3'b100);
        check("R10 survives", int'(sticky), 4);
        apply("R10 hold", 2'd1, 12'd5, 3'b000);
        clear(3'b111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 20000 expected 0 cycles left");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_under();
        t_window();
        t_over();
        t_escape();
        t_signed();
        t_off_and_isolation();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule